// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is a host-side master that turns write requests into serial frames for an 8-bit voltage-output converter. A request on a valid/ready handshake carries the 8-bit output code plus two mode flags: one selects the fast settling mode and one selects power-down. The controller packs these into a 16-bit word and sends it most significant bit first. The converter samples data on the falling edges of the serial clock inside a window that opens when frame sync falls. A separate active-low chip select frames the whole transfer.

Every timing interval is a whole number of system clock cycles and is set by a parameter. These are the serial clock half-period, the chip-select-to-frame-sync setup, the frame-sync-to-first-edge setup, the hold after the last rising edge and the idle gap between frames. With suitable values the interface meets the converter's minimum pulse widths, setup times and hold times. The data line only moves on rising serial clock edges, so it is stable across every falling edge. A busy flag covers the whole transfer, and a one-cycle done pulse marks the point where a new request can be taken.

Top module: `dac_wr_ctrl`

## Requirements
- R1: While reset is low, and immediately when it is asserted even in the middle of a frame, the outputs are chip select high, frame sync high, serial clock high, data low, busy low and done low. Once reset has been released, ready is high.
- R2: A request is taken on a rising edge where valid and ready are both high. From the next cycle, chip select is low and busy is high. Ready stays low until the transfer ends, and request data that changes during a transfer has no effect on the frame being sent.
- R3: The frame is 16 bits and is sent MSB first. Bit 15 is 0, bit 14 is the fast flag, bit 13 is the power-down flag, bit 12 is 0, bits 11 to 4 hold the code and bits 3 to 0 are 0.
- R4: Chip select falls exactly CS_SETUP cycles before frame sync falls, and frame sync is only low while chip select is low.
- R5: Frame sync falls exactly FS_SETUP + DIV_HALF cycles before the first falling serial clock edge. The serial clock is held high whenever chip select is high.
- R6: Each serial clock low phase lasts exactly DIV_HALF cycles, and so does each high phase between falling edges. A frame has exactly 16 falling edges and 16 rising edges.
- R7: The data line changes only in a cycle in which the serial clock rises.
- R8: Chip select and frame sync rise together, exactly CS_HOLD cycles after the 16th rising serial clock edge.
- R9: Chip select stays high for exactly GAP_CYC cycles. Ready then returns, and done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller can take a request |
| req_code | input | 8 | Converter output code |
| req_fast | input | 1 | Selects fast settling mode |
| req_pdn | input | 1 | Selects power-down |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_fs | output | 1 | Frame sync, low during the data window |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_din | output | 1 | Serial data |

## Verification
The in-line assertions check several properties on every cycle. They check that frame sync is never low without chip select, that the serial clock stays high while chip select is high, and that the data line moves only with a rising serial clock. They also check that an accepted request pulls chip select low the next cycle, that the edge count never passes 16, and that done never lasts two cycles. The exact cycle distances between the interface events, the bit order and padding of the captured word, and the data-freeze behaviour when request inputs change mid-frame are shown only by the bench. The bench reconstructs each frame from the pins and times every event. Recovery from a reset applied in the middle of a frame is also shown only by a bench scenario.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

  localparam int FRAME_W = 16;
  localparam int CODE_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_FS_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  // Word layout: pad, fast, power-down, pad, code, four zero pad bits.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [CODE_W-1:0] code,
    input logic              fast,
    input logic              pdn
  );
    build_frame = {1'b0, fast, pdn, 1'b0, code, 4'b0000};
  endfunction

  function automatic int max_of5(input int a, input int b, input int c,
                                 input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dac_wait_timer.sv
module dac_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dac_frame_sreg.sv
module dac_frame_sreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] sreg_q;
  logic [W-1:0] sreg_d;
  logic         sreg_en;

  always_comb begin
    sreg_en = load || shift;
    if (load) sreg_d = load_word;
    else      sreg_d = {sreg_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg_q <= '0;
    else if (sreg_en) sreg_q <= sreg_d;
  end

  assign msb = sreg_q[W-1];

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int DIV_HALF = 7,
  parameter int CS_SETUP = 3,
  parameter int FS_SETUP = 2,
  parameter int CS_HOLD  = 3,
  parameter int GAP_CYC  = 5,
  parameter int TMR_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             tmr_expired,
  output logic             req_ready,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             fs,
  output logic             sclk,
  output logic             frame_load,
  output logic             shift_en,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [TMR_W-1:0] LD_HALF = TMR_W'(DIV_HALF - 1);
  localparam logic [TMR_W-1:0] LD_CS   = TMR_W'(CS_SETUP - 1);
  localparam logic [TMR_W-1:0] LD_FS   = TMR_W'(FS_SETUP - 1);
  localparam logic [TMR_W-1:0] LD_HOLD = TMR_W'(CS_HOLD - 1);
  localparam logic [TMR_W-1:0] LD_GAP  = TMR_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_W);

  seq_state_e       st_q, st_d;
  logic             cs_q, cs_d;
  logic             fs_q, fs_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] fall_q, fall_d;

  always_comb begin
    st_d       = st_q;
    cs_d       = cs_q;
    fs_d       = fs_q;
    sclk_d     = sclk_q;
    fall_d     = fall_q;
    done_d     = 1'b0;
    frame_load = 1'b0;
    shift_en   = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          frame_load = 1'b1;
          st_d       = ST_CS_SETUP;
          cs_d       = 1'b0;
          fall_d     = '0;
          tmr_load   = 1'b1;
          tmr_val    = LD_CS;
        end
      end
      ST_CS_SETUP: begin
        if (tmr_expired) begin
          st_d     = ST_FS_SETUP;
          fs_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = LD_FS;
        end
      end
      ST_FS_SETUP: begin
        if (tmr_expired) begin
          st_d     = ST_SHIFT;
          tmr_load = 1'b1;
          tmr_val  = LD_HALF;
        end
      end
      ST_SHIFT: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = LD_HALF;
          sclk_d   = !sclk_q;
          if (sclk_q) begin
            fall_d = fall_q + CNT_W'(1);
          end else if (fall_q == LAST_EDGE) begin
            st_d    = ST_HOLD;
            tmr_val = LD_HOLD;
          end else begin
            shift_en = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_expired) begin
          st_d     = ST_GAP;
          cs_d     = 1'b1;
          fs_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_GAP;
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cs_q   <= 1'b1;
      fs_q   <= 1'b1;
      sclk_q <= 1'b1;
      done_q <= 1'b0;
      fall_q <= '0;
    end else begin
      st_q   <= st_d;
      cs_q   <= cs_d;
      fs_q   <= fs_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      fall_q <= fall_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign cs_n      = cs_q;
  assign fs        = fs_q;
  assign sclk      = sclk_q;

  AST_ACCEPT_DROPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!cs_q && busy && !req_ready)); // R2
  AST_FS_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_q |-> !cs_q); // R4
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_q); // R5
  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q <= LAST_EDGE); // R6
  AST_CS_FS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> $rose(fs_q)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9

endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl
  import dac_wr_pkg::*;
#(
  parameter int DIV_HALF    = 7,
  parameter int CS_SETUP    = 3,
  parameter int FS_SETUP    = 2,
  parameter int CS_HOLD     = 3,
  parameter int GAP_CYC     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_fast,
  input  logic              req_pdn,
  output logic              busy,
  output logic              done,
  output logic              dac_cs_n,
  output logic              dac_fs,
  output logic              dac_sclk,
  output logic              dac_din
);

  localparam int MAX_WAIT = max_of5(DIV_HALF, CS_SETUP, FS_SETUP, CS_HOLD, GAP_CYC);
  localparam int TMR_W    = $clog2(MAX_WAIT + 1);

  logic             rst_n_i;
  logic             tmr_expired;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             frame_load;
  logic             shift_en;
  logic [FRAME_W-1:0] frame_word;

  assign frame_word = build_frame(req_code, req_fast, req_pdn);

  dac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  dac_wait_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dac_frame_sreg #(.W(FRAME_W)) u_sreg (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (frame_load),
    .load_word (frame_word),
    .shift     (shift_en),
    .msb       (dac_din)
  );

  dac_wr_seq #(
    .DIV_HALF (DIV_HALF),
    .CS_SETUP (CS_SETUP),
    .FS_SETUP (FS_SETUP),
    .CS_HOLD  (CS_HOLD),
    .GAP_CYC  (GAP_CYC),
    .TMR_W    (TMR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .req_valid   (req_valid),
    .tmr_expired (tmr_expired),
    .req_ready   (req_ready),
    .busy        (busy),
    .done        (done),
    .cs_n        (dac_cs_n),
    .fs          (dac_fs),
    .sclk        (dac_sclk),
    .frame_load  (frame_load),
    .shift_en    (shift_en),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  AST_DIN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n_i)
    !$stable(dac_din) |-> $rose(dac_sclk)); // R7

endmodule

// File: tb/test_dac_wr_ctrl.sv
module test_dac_wr_ctrl;

  localparam int DIV_HALF = 7;
  localparam int CS_SETUP = 3;
  localparam int FS_SETUP = 2;
  localparam int CS_HOLD  = 3;
  localparam int GAP_CYC  = 5;
  localparam int NVEC     = 6;

  // {fast, pdn, code, expected 16-bit word}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 16'h0000},
    {1'b1, 1'b0, 8'hFF, 16'h4FF0},
    {1'b0, 1'b1, 8'hA5, 16'h2A50},
    {1'b1, 1'b1, 8'h5A, 16'h65A0},
    {1'b0, 1'b0, 8'h80, 16'h0800},
    {1'b1, 1'b0, 8'h01, 16'h4010}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [7:0] req_code;
  logic       req_fast;
  logic       req_pdn;
  logic       busy, done;
  logic       dac_cs_n, dac_fs, dac_sclk, dac_din;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dac_wr_ctrl #(
    .DIV_HALF (DIV_HALF), .CS_SETUP (CS_SETUP), .FS_SETUP (FS_SETUP),
    .CS_HOLD  (CS_HOLD),  .GAP_CYC  (GAP_CYC),  .SYNC_STAGES (2)
  ) i_dac_wr_ctrl (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_code (req_code), .req_fast (req_fast), .req_pdn (req_pdn),
    .busy (busy), .done (done), .dac_cs_n (dac_cs_n), .dac_fs (dac_fs),
    .dac_sclk (dac_sclk), .dac_din (dac_din)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check_idle_pins(input string req);
    chk(req, "cs_n", int'(dac_cs_n), 1);
    chk(req, "fs", int'(dac_fs), 1);
    chk(req, "sclk", int'(dac_sclk), 1);
    chk(req, "din", int'(dac_din), 0);
    chk(req, "busy", int'(busy), 0);
    chk(req, "done", int'(done), 0);
  endtask

  // Sends one word and times every pin event from the acceptance edge.
  task automatic xfer(input logic fast, input logic pdn, input logic [7:0] code,
                      input logic [15:0] exp_word, input bit hold_valid);
    logic p_cs, p_fs, p_sclk, p_din;
    logic [15:0] cap;
    int cyc, n_fall, n_rise, t_last, t_csf, t_fsf, t_f1, t_lr, t_csr, t_fsr, t_done;
    int bad_phase, bad_din, bad_ready, bad_park;
    cap = '0; n_fall = 0; n_rise = 0; t_last = 0; t_csf = -1; t_fsf = -1; t_f1 = -1;
    t_lr = -1; t_csr = -1; t_fsr = -1; t_done = -1;
    bad_phase = 0; bad_din = 0; bad_ready = 0; bad_park = 0;
    @(negedge clk);
    req_valid = 1'b1; req_fast = fast; req_pdn = pdn; req_code = code;
    chk("R2", "ready before accept", int'(req_ready), 1);
    p_cs = dac_cs_n; p_fs = dac_fs; p_sclk = dac_sclk; p_din = dac_din;
    for (cyc = 1; cyc < 2000; cyc++) begin
      @(negedge clk);
      if (!hold_valid) req_valid = 1'b0;
      else begin
        req_code = ~code; req_fast = ~fast; req_pdn = ~pdn;
      end
      if (cyc == 1) chk("R2", "cs_n low after accept", int'(dac_cs_n), 0);
      if (p_cs && !dac_cs_n) t_csf = cyc;
      if (p_fs && !dac_fs) t_fsf = cyc;
      if (!p_cs && dac_cs_n) t_csr = cyc;
      if (!p_fs && dac_fs) t_fsr = cyc;
      if (dac_cs_n && !dac_sclk) bad_park++;
      if (p_sclk && !dac_sclk) begin
        n_fall++;
        if (n_fall == 1) t_f1 = cyc;
        else if (cyc - t_last != DIV_HALF) bad_phase++;
        t_last = cyc;
        cap = {cap[14:0], dac_din};
      end
      if (!p_sclk && dac_sclk) begin
        n_rise++;
        if (cyc - t_last != DIV_HALF) bad_phase++;
        t_last = cyc;
        t_lr = cyc;
      end
      if ((dac_din != p_din) && !(!p_sclk && dac_sclk)) bad_din++;
      if (done) begin
        t_done = cyc;
        req_valid = 1'b0;
        break;
      end
      if (req_ready || !busy) bad_ready++;
      p_cs = dac_cs_n; p_fs = dac_fs; p_sclk = dac_sclk; p_din = dac_din;
    end
    chk("R3", "captured word", int'(cap), int'(exp_word));
    chk("R6", "falling edges", n_fall, 16);
    chk("R6", "rising edges", n_rise, 16);
    chk("R6", "phase length errors", bad_phase, 0);
    chk("R4", "cs to fs setup", t_fsf - t_csf, CS_SETUP);
    chk("R5", "fs to first fall", t_f1 - t_fsf, FS_SETUP + DIV_HALF);
    chk("R5", "sclk low while deselected", bad_park, 0);
    chk("R7", "din moves off rising edge", bad_din, 0);
    chk("R8", "hold after last rise", t_csr - t_lr, CS_HOLD);
    chk("R8", "fs rises with cs", t_fsr, t_csr);
    chk("R9", "gap before done", t_done - t_csr, GAP_CYC);
    chk("R2", "ready or busy wrong during frame", bad_ready, 0);
    chk("R9", "ready with done", int'(req_ready), 1);
    @(negedge clk);
    chk("R9", "done width", int'(done), 0);
    chk("R9", "no restart", int'(dac_cs_n), 1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; req_fast = 1'b0; req_pdn = 1'b0;
    repeat (3) @(negedge clk);
    check_idle_pins("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ready after reset", int'(req_ready), 1);
    check_idle_pins("R1");

    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:0], 1'b0);
      repeat (2) @(negedge clk);
    end

    // R2: request inputs toggled and valid held during a frame are ignored
    xfer(1'b1, 1'b0, 8'h3C, 16'h43C0, 1'b1);

    // R1: reset asserted in the middle of a frame
    @(negedge clk);
    req_valid = 1'b1; req_code = 8'hC3; req_fast = 1'b0; req_pdn = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk("R1", "frame running before abort", int'(dac_cs_n), 0);
    rst_n = 1'b0;
    #1;
    check_idle_pins("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    xfer(1'b0, 1'b1, 8'hC3, 16'h2C30, 1'b0);

    finish_run();
  end

endmodule